// File: doc/BRIEF.md
# Vector Pair Transpose Permute Unit

This block carries out the pairwise transpose permutation of a SIMD instruction set. It receives a 32-bit instruction word and two 128-bit source vectors. It decodes the word and reports an illegal encoding when the word does not match or when its fields form a reserved combination. It then builds a destination vector in which the two sources alternate, one element of each pair from each source. The element width and the vector width come from fields of the instruction. A selector bit picks the even or the odd element of each source pair, so one datapath serves both the primary and the secondary transpose.

The register index fields are passed through unchanged, so that a register file outside the block can use them. By default the outputs are registered. They appear one cycle after an input strobe, together with a valid bit. A parameter removes the register and leaves a purely combinational path.

Top module: `vtrn_unit`

## Requirements
- R1: A word is legal only when bit 31 is 0, bits 29:24 are 6'b001110, bit 21 is 0, bit 15 is 0 and bits 13:10 are 4'b1010. Any other value of these bits raises `illegal`.
- R2: A size field (bits 23:22) of 2'b11 together with Q (bit 30) equal to 0 is reserved and raises `illegal`.
- R3: Whenever `illegal` is high, `result` is all zero.
- R4: The element width is 8 << size bits. Q = 1 gives a 128-bit operation and Q = 0 gives a 64-bit operation.
- R5: The part bit is bit 14. For each pair index p, destination element 2p takes element 2p+part of `src_a`, and destination element 2p+1 takes element 2p+part of `src_b`. Element 0 sits at bit 0.
- R6: When Q = 0, `result[127:64]` is zero.
- R7: `rd_idx`, `rn_idx` and `rm_idx` carry instruction bits 4:0, 9:5 and 20:16.
- R8: In the registered variant, all outputs reflect the inputs sampled at a clock edge where `in_valid` is high. `out_valid` is high exactly in the cycle after such an edge. The data outputs hold their value while `in_valid` is low.
- R9: Reset drives every registered output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; also the register enable |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Destination vector |
| illegal | output | 1 | Encoding not legal |
| rd_idx | output | 5 | Destination register index |
| rn_idx | output | 5 | First source register index |
| rm_idx | output | 5 | Second source register index |

## Verification
Random operands are applied under every combination of the four element sizes, both widths and both part values. This separates a wrong element stride, a wrong choice of source in the pair, and a leak into the upper half. A fixed pattern with distinct 32-bit words shows directly which source element lands in which slot. Every fixed opcode bit is flipped on its own, so that a decoder that ignores any one of them is exposed. The reserved size-and-width combination is also driven. Idle cycles after a transfer show whether the data holds and the valid bit drops.

// File: rtl/vtrn_pkg.sv
package vtrn_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;

  typedef struct packed {
    logic             legal;
    logic             q;
    logic [1:0]       size;
    logic             part;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
  } vtrn_dec_t;
endpackage

// File: rtl/vtrn_decode.sv
module vtrn_decode
  import vtrn_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output vtrn_dec_t          dec
);
  logic fixed_ok;
  logic reserved;

  always_comb begin
    fixed_ok = (instr[31] == 1'b0) && (instr[29:24] == 6'b001110) &&
               (instr[21] == 1'b0) && (instr[15] == 1'b0) &&
               (instr[13:10] == 4'b1010);
    reserved = (instr[23:22] == 2'b11) && !instr[30];
    dec.legal = fixed_ok && !reserved;
    dec.q     = instr[30];
    dec.size  = instr[23:22];
    dec.part  = instr[14];
    dec.rd    = instr[4:0];
    dec.rn    = instr[9:5];
    dec.rm    = instr[20:16];
  end
endmodule

// File: rtl/vtrn_permute.sv
module vtrn_permute #(
  parameter int VEC_W     = 128,
  parameter int NUM_SIZES = 4
) (
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [1:0]       size,
  input  logic             part,
  output logic [VEC_W-1:0] perm
);
  logic [VEC_W-1:0] cand [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int NE = VEC_W / EW;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      if (e % 2 == 0) begin : g_even
        // even slot: first source, element e (part 0) or e+1 (part 1)
        assign cand[s][e*EW +: EW] = part ? src_a[(e+1)*EW +: EW]
                                          : src_a[e*EW +: EW];
      end else begin : g_odd
        // odd slot: second source, element e-1 (part 0) or e (part 1)
        assign cand[s][e*EW +: EW] = part ? src_b[e*EW +: EW]
                                          : src_b[(e-1)*EW +: EW];
      end
    end
  end

  always_comb begin
    perm = cand[0];
    for (int s = 1; s < NUM_SIZES; s++) begin
      if (size == 2'(s)) perm = cand[s];
    end
  end
endmodule

// File: rtl/vtrn_unit.sv
module vtrn_unit
  import vtrn_pkg::*;
#(
  parameter int VEC_W      = 128,
  parameter int NUM_SIZES  = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        instr,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               illegal,
  output logic [4:0]         rd_idx,
  output logic [4:0]         rn_idx,
  output logic [4:0]         rm_idx
);
  localparam int HALF_W = VEC_W / 2;

  vtrn_dec_t        dec;
  logic [VEC_W-1:0] perm;
  logic [VEC_W-1:0] res_nxt;

  vtrn_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  vtrn_permute #(.VEC_W(VEC_W), .NUM_SIZES(NUM_SIZES)) u_perm (
    .src_a (src_a),
    .src_b (src_b),
    .size  (dec.size),
    .part  (dec.part),
    .perm  (perm)
  );

  always_comb begin
    if (!dec.legal)  res_nxt = '0;
    else if (dec.q)  res_nxt = perm;
    else             res_nxt = {{HALF_W{1'b0}}, perm[HALF_W-1:0]};
  end

  if (REGISTERED) begin : g_reg
    logic             vld_q;
    logic [VEC_W-1:0] res_q;
    logic             ill_q;
    logic [4:0]       rd_q, rn_q, rm_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        ill_q <= 1'b0;
        rd_q  <= '0;
        rn_q  <= '0;
        rm_q  <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) begin
          res_q <= res_nxt;
          ill_q <= !dec.legal;
          rd_q  <= dec.rd;
          rn_q  <= dec.rn;
          rm_q  <= dec.rm;
        end
      end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
    assign illegal   = ill_q;
    assign rd_idx    = rd_q;
    assign rn_idx    = rn_q;
    assign rm_idx    = rm_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = res_nxt;
    assign illegal   = !dec.legal;
    assign rd_idx    = dec.rd;
    assign rn_idx    = dec.rn;
    assign rm_idx    = dec.rm;
  end
endmodule

// File: rtl/vtrn_checker.sv
module vtrn_checker #(
  parameter int VEC_W      = 128,
  parameter bit REGISTERED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             illegal,
  input logic [4:0]       rd_idx,
  input logic [4:0]       rn_idx,
  input logic [4:0]       rm_idx
);
  localparam int HALF_W = VEC_W / 2;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3: an illegal word never leaves data on the result
  a_r3_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));

  if (REGISTERED) begin : g_reg_chk
    // R8: valid follows the strobe by exactly one cycle
    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == $past(in_valid)));
    // R8: data holds without a strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_valid)) |-> $stable(result));
    // R6: narrow operation leaves the upper half clear
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid) && !$past(instr[30])) |-> (result[VEC_W-1:HALF_W] == '0));
    // R7: index fields pass through
    a_r7_idx_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid)) |->
        ({rm_idx, rn_idx, rd_idx} == {$past(instr[20:16]), $past(instr[9:5]), $past(instr[4:0])}));
    // R1: a set top bit is always flagged
    a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid) && $past(instr[31])) |-> illegal);
    // R2: reserved size with narrow width is flagged
    a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid) && ($past(instr[23:22]) == 2'b11) && !$past(instr[30])) |-> illegal);
  end else begin : g_comb_chk
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !instr[30] |-> (result[VEC_W-1:HALF_W] == '0));
    a_r7_idx_pass: assert property (@(posedge clk) disable iff (!rst_n)
      {rm_idx, rn_idx, rd_idx} == {instr[20:16], instr[9:5], instr[4:0]});
    a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      instr[31] |-> illegal);
    a_r8_valid_pass: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
  end
endmodule

bind vtrn_unit vtrn_checker #(.VEC_W(VEC_W), .REGISTERED(REGISTERED)) u_vtrn_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal),
  .rd_idx    (rd_idx),
  .rn_idx    (rn_idx),
  .rm_idx    (rm_idx)
);

// File: tb/vtrn_unit_bench.sv
module vtrn_unit_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src_a, src_b;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;
  logic [4:0]   rd_idx, rn_idx, rm_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  vtrn_unit u_vtrn_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .illegal(illegal), .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(input logic q, input logic [1:0] sz, input logic part,
                                     input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {1'b0, q, 6'b001110, sz, 1'b0, rm, 1'b0, part, 4'b1010, rn, rd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // reference: walk pairs of the operation width and copy the selected element
  function automatic logic [127:0] ref_model(input logic q, input logic [1:0] sz, input logic part,
                                             input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    int esz;
    int dsz;
    r = '0;
    esz = 8 << sz;
    dsz = q ? 128 : 64;
    if (sz == 2'b11 && !q) return '0;
    for (int p = 0; p < dsz / (2 * esz); p++) begin
      for (int k = 0; k < esz; k++) begin
        r[(2*p)*esz + k]   = a[(2*p + part)*esz + k];
        r[(2*p+1)*esz + k] = b[(2*p + part)*esz + k];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_a = a; src_b = b;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R9 out_valid", {127'b0, out_valid}, '0);
    chk("R9 result", result, '0);
    chk("R9 illegal", {127'b0, illegal}, '0);
    chk("R9 idx", {113'b0, rd_idx, rn_idx, rm_idx}, '0);
  endtask

  task automatic t_sweep();
    for (int sz = 0; sz < 4; sz++)
      for (int q = 0; q < 2; q++)
        for (int pt = 0; pt < 2; pt++)
          for (int n = 0; n < 3; n++) begin
            logic [127:0] a, b;
            logic [4:0] rd, rn, rm;
            logic exp_ill;
            a = rnd128(); b = rnd128();
            rd = 5'($urandom()); rn = 5'($urandom()); rm = 5'($urandom());
            apply(mk(q[0], sz[1:0], pt[0], rm, rn, rd), a, b);
            exp_ill = (sz == 3) && (q == 0);
            chk("R4 R5 R6 result", result, ref_model(q[0], sz[1:0], pt[0], a, b));
            chk("R2 illegal", {127'b0, illegal}, {127'b0, exp_ill});
            chk("R6 upper", {64'b0, result[127:64]}, q[0] ? {64'b0, result[127:64]} : '0);
            chk("R7 idx", {113'b0, rd_idx, rn_idx, rm_idx}, {113'b0, rd, rn, rm});
            chk("R8 out_valid", {127'b0, out_valid}, 128'd1);
          end
  endtask

  task automatic t_known();
    logic [127:0] a, b;
    a = {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0A0A0A0};
    b = {32'hB3B3B3B3, 32'hB2B2B2B2, 32'hB1B1B1B1, 32'hB0B0B0B0};
    apply(mk(1'b1, 2'd2, 1'b1, 5'd2, 5'd1, 5'd0), a, b);
    chk("R5 odd", result, {32'hB3B3B3B3, 32'hA3A3A3A3, 32'hB1B1B1B1, 32'hA1A1A1A1});
    apply(mk(1'b1, 2'd2, 1'b0, 5'd2, 5'd1, 5'd0), a, b);
    chk("R5 even", result, {32'hB2B2B2B2, 32'hA2A2A2A2, 32'hB0B0B0B0, 32'hA0A0A0A0});
    apply(mk(1'b0, 2'd2, 1'b1, 5'd2, 5'd1, 5'd0), a, b);
    chk("R6 narrow", result, {64'b0, 32'hB1B1B1B1, 32'hA1A1A1A1});
    apply(mk(1'b1, 2'd3, 1'b1, 5'd2, 5'd1, 5'd0), a, b);
    chk("R4 dword", result, {32'hB3B3B3B3, 32'hB2B2B2B2, 32'hA3A3A3A3, 32'hA2A2A2A2});
  endtask

  task automatic t_illegal();
    int pos [14] = '{31, 29, 28, 27, 26, 25, 24, 21, 15, 13, 12, 11, 10, 0};
    for (int i = 0; i < 13; i++) begin
      logic [31:0] w;
      w = mk(1'b1, 2'd0, 1'b1, 5'd3, 5'd4, 5'd5);
      w[pos[i]] = ~w[pos[i]];
      apply(w, rnd128(), rnd128());
      chk($sformatf("R1 bit %0d illegal", pos[i]), {127'b0, illegal}, 128'd1);
      chk("R3 zero", result, '0);
    end
    apply(mk(1'b0, 2'd3, 1'b0, 5'd1, 5'd1, 5'd1), rnd128(), rnd128());
    chk("R2 reserved", {127'b0, illegal}, 128'd1);
    chk("R3 reserved zero", result, '0);
  endtask

  task automatic t_hold();
    logic [127:0] a, b, exp;
    a = rnd128(); b = rnd128();
    exp = ref_model(1'b1, 2'd0, 1'b0, a, b);
    apply(mk(1'b1, 2'd0, 1'b0, 5'd7, 5'd8, 5'd9), a, b);
    chk("R8 captured", result, exp);
    @(negedge clk);
    instr = mk(1'b1, 2'd1, 1'b1, 5'd1, 5'd1, 5'd1); src_a = rnd128(); src_b = rnd128();
    @(posedge clk); #1;
    chk("R8 valid drop", {127'b0, out_valid}, '0);
    @(posedge clk); #1;
    chk("R8 hold", result, exp);
    chk("R8 hold idx", {113'b0, rd_idx, rn_idx, rm_idx}, {113'b0, 5'd9, 5'd8, 5'd7});
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_known();
    t_sweep();
    t_illegal();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule